// File: doc/BRIEF.md
# Lockable System Options and Debug Reset Register Bank

This block holds system settings that software is expected to set once, early in the boot code, and then leave alone. It has two locations on a simple 8-bit CPU bus. The options location drives five configuration outputs: watchdog enable, watchdog long-timeout select, stop-mode enable, debug-pin enable and reset-pin enable. It also keeps one spare bit that can be read back. After each reset the CPU may write the options location only once. The bank then locks until the next reset, which protects the settings from stray writes.

The second location is a force-reset control. The CPU can never set it. It reacts only to writes on a separate debug write port. A debug write that carries a 1 in bit 0 produces a one-cycle system reset request on the cycle after the write. This control holds no state and always reads back as zero. The watchdog itself, the debug serial protocol and the reset sequencer are outside this block.

Top module: `syscfg_lockbank`

## Requirements
- R1: After a synchronous reset the options location reads 0xD2. Bit 7 (watchdog enable), bit 6 (long-timeout select), bit 4 (spare) and bit 1 (debug-pin enable) are 1. Bit 5 (stop enable) and bit 0 (reset-pin enable) are 0.
- R2: A read of the options address returns the current stored bits at any time. Bits 3 and 2 always read 0.
- R3: The first CPU write to the options address after reset stores write-data bits 7, 6, 5, 4, 1 and 0. The new value is visible from the next cycle.
- R4: Every later CPU write to the options address is ignored until the next reset, even when it carries the reset values.
- R5: A CPU write in the same cycle as reset is dropped and does not lock the bank. The next write after reset is still accepted.
- R6: A read of the force-reset address always returns 0x00.
- R7: A CPU write to the force-reset address never raises the reset request.
- R8: A debug write to the force-reset address with bit 0 = 1 raises sys_rst_req for exactly the following cycle. With bit 0 = 0, or to any other address, it raises nothing.
- R9: When the CPU and the debug port write in the same cycle, the debug write alone decides the reset request. The CPU write to the options address is processed as if alone.
- R10: Addresses other than the two mapped ones read 0x00. CPU writes to them change nothing and do not lock the bank.
- R11: Each configuration output equals its stored bit: cfg_wdog_en bit 7, cfg_wdog_long bit 6, cfg_stop_en bit 5, cfg_dbgpin_en bit 1, cfg_rstpin_en bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_we | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data (combinational on bus_addr) |
| dbg_we | input | 1 | Debug port write strobe |
| dbg_addr | input | ADDR_W | Debug port address |
| dbg_wdata | input | 8 | Debug port write data |
| cfg_wdog_en | output | 1 | Watchdog enable |
| cfg_wdog_long | output | 1 | Watchdog long-timeout select |
| cfg_stop_en | output | 1 | Stop-mode enable |
| cfg_dbgpin_en | output | 1 | Debug-pin enable |
| cfg_rstpin_en | output | 1 | Reset-pin enable |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The checker watches four things on every cycle. Bits 3 and 2 read as zero, and the force-reset address reads zero. The outputs stay frozen once a first options write has been taken. Every reset-request pulse is tied to a debug write with bit 0 set on the cycle before, and such a write always produces one. The bench scenarios cover the rest. They check the exact reset value, that the same-cycle reset and write leaves the bank unlocked, and that writes to unmapped addresses do not lock it. They also check the combined CPU and debug write on an unlocked bank and the mapping of each output to its stored bit.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    localparam int DATA_W   = 8;
    localparam int FRC_BIT  = 0;

    typedef struct packed {
        logic wdog_en;    // byte bit 7
        logic wdog_long;  // byte bit 6
        logic stop_en;    // byte bit 5
        logic spare;      // byte bit 4
        logic dbgpin_en;  // byte bit 1
        logic rstpin_en;  // byte bit 0
    } opt_t;

    localparam opt_t OPT_DEFAULT = '{
        wdog_en:   1'b1,
        wdog_long: 1'b1,
        stop_en:   1'b0,
        spare:     1'b1,
        dbgpin_en: 1'b1,
        rstpin_en: 1'b0
    };

    function automatic logic [DATA_W-1:0] opt_to_byte(opt_t o);
        return {o.wdog_en, o.wdog_long, o.stop_en, o.spare,
                2'b00, o.dbgpin_en, o.rstpin_en};
    endfunction

    function automatic opt_t byte_to_opt(logic [DATA_W-1:0] b);
        opt_t o;
        o.wdog_en   = b[7];
        o.wdog_long = b[6];
        o.stop_en   = b[5];
        o.spare     = b[4];
        o.dbgpin_en = b[1];
        o.rstpin_en = b[0];
        return o;
    endfunction

    function automatic logic frc_request(logic [DATA_W-1:0] b);
        return b[FRC_BIT];
    endfunction

endpackage

// File: rtl/syscfg_decode.sv
module syscfg_decode
    import syscfg_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR = '0,
    parameter logic [ADDR_W-1:0] FRC_ADDR = 1
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              dbg_we,
    input  opt_t              opt_q,
    output logic              opt_wr,
    output logic              frc_hit,
    output logic [DATA_W-1:0] rdata
);
    // CPU writes reach only the options location; the debug port reaches only force-reset.
    assign opt_wr  = bus_we && (bus_addr == OPT_ADDR);
    assign frc_hit = dbg_we && (dbg_addr == FRC_ADDR);

    always_comb begin
        rdata = '0;
        if (bus_addr == OPT_ADDR)
            rdata = opt_to_byte(opt_q);
        // force-reset location and unmapped addresses read zero
    end
endmodule

// File: rtl/syscfg_optreg.sv
module syscfg_optreg
    import syscfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output opt_t              q
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= OPT_DEFAULT;
            locked_q <= 1'b0;
        end else if (wr && !locked_q) begin
            q        <= byte_to_opt(wdata);
            locked_q <= 1'b1;
        end
    end
endmodule

// File: rtl/syscfg_frcreset.sv
module syscfg_frcreset
    import syscfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              req
);
    // Self-clearing: the flop reloads every cycle, so a request lasts one cycle per write.
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= hit && frc_request(wdata);
    end
endmodule

// File: rtl/syscfg_lockbank.sv
module syscfg_lockbank
    import syscfg_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR = '0,
    parameter logic [ADDR_W-1:0] FRC_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [7:0]        dbg_wdata,
    output logic              cfg_wdog_en,
    output logic              cfg_wdog_long,
    output logic              cfg_stop_en,
    output logic              cfg_dbgpin_en,
    output logic              cfg_rstpin_en,
    output logic              sys_rst_req
);
    opt_t opt_q;
    logic opt_wr;
    logic frc_hit;

    syscfg_decode #(
        .ADDR_W  (ADDR_W),
        .OPT_ADDR(OPT_ADDR),
        .FRC_ADDR(FRC_ADDR)
    ) u_dec (
        .bus_addr(bus_addr),
        .bus_we  (bus_we),
        .dbg_addr(dbg_addr),
        .dbg_we  (dbg_we),
        .opt_q   (opt_q),
        .opt_wr  (opt_wr),
        .frc_hit (frc_hit),
        .rdata   (bus_rdata)
    );

    syscfg_optreg u_opt (
        .clk  (clk),
        .rst  (rst),
        .wr   (opt_wr),
        .wdata(bus_wdata),
        .q    (opt_q)
    );

    syscfg_frcreset u_frc (
        .clk  (clk),
        .rst  (rst),
        .hit  (frc_hit),
        .wdata(dbg_wdata),
        .req  (sys_rst_req)
    );

    assign cfg_wdog_en   = opt_q.wdog_en;
    assign cfg_wdog_long = opt_q.wdog_long;
    assign cfg_stop_en   = opt_q.stop_en;
    assign cfg_dbgpin_en = opt_q.dbgpin_en;
    assign cfg_rstpin_en = opt_q.rstpin_en;
endmodule

// File: rtl/syscfg_lockbank_chk.sv
module syscfg_lockbank_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OPT_ADDR = '0,
    parameter logic [ADDR_W-1:0] FRC_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              dbg_we,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [7:0]        dbg_wdata,
    input logic              cfg_wdog_en,
    input logic              cfg_wdog_long,
    input logic              cfg_stop_en,
    input logic              cfg_dbgpin_en,
    input logic              cfg_rstpin_en,
    input logic              sys_rst_req
);
    logic live_q  = 1'b0;
    logic wrote_q = 1'b0;
    logic rst_q   = 1'b0;
    logic [4:0] outs;
    logic dbg_set;
    logic cpu_opt_wr;

    assign outs       = {cfg_wdog_en, cfg_wdog_long, cfg_stop_en, cfg_dbgpin_en, cfg_rstpin_en};
    assign dbg_set    = dbg_we && (dbg_addr == FRC_ADDR) && dbg_wdata[0];
    assign cpu_opt_wr = bus_we && (bus_addr == OPT_ADDR);

    always_ff @(posedge clk) begin
        rst_q   <= rst;
        live_q  <= live_q | rst;
        wrote_q <= rst ? 1'b0 : (wrote_q | cpu_opt_wr);
        if (rst_q) begin
            a_r1_reset_defaults: assert (outs == 5'b11010 && sys_rst_req == 1'b0)
                else $error("R1 outputs after reset %b", outs);
        end
    end

    a_r2_unimpl_bits_zero: assert property (@(posedge clk) disable iff (rst || !live_q)
        (bus_addr == OPT_ADDR) |-> (bus_rdata[3:2] == 2'b00));

    a_r3_first_write_taken: assert property (@(posedge clk) disable iff (rst || !live_q)
        (!wrote_q && cpu_opt_wr) |=>
        (outs == {$past(bus_wdata[7]), $past(bus_wdata[6]), $past(bus_wdata[5]),
                  $past(bus_wdata[1]), $past(bus_wdata[0])}));

    a_r4_locked_stable: assert property (@(posedge clk) disable iff (rst || !live_q)
        wrote_q |=> $stable(outs));

    a_r6_frc_reads_zero: assert property (@(posedge clk) disable iff (rst || !live_q)
        (bus_addr == FRC_ADDR) |-> (bus_rdata == 8'h00));

    a_r7_only_debug_source: assert property (@(posedge clk) disable iff (rst || !live_q)
        sys_rst_req |-> $past(dbg_set));

    a_r8_debug_pulse: assert property (@(posedge clk) disable iff (rst || !live_q)
        dbg_set |=> sys_rst_req);
endmodule

bind syscfg_lockbank syscfg_lockbank_chk #(
    .ADDR_W  (ADDR_W),
    .OPT_ADDR(OPT_ADDR),
    .FRC_ADDR(FRC_ADDR)
) u_chk (.*);

// File: tb/sim_syscfg_lockbank.sv
module sim_syscfg_lockbank;
    localparam logic [7:0] A_OPT = 8'h00;
    localparam logic [7:0] A_FRC = 8'h01;
    localparam logic [7:0] A_NONE = 8'h05;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dbg_we = 1'b0;
    logic [7:0] dbg_addr = '0;
    logic [7:0] dbg_wdata = '0;
    logic cfg_wdog_en, cfg_wdog_long, cfg_stop_en, cfg_dbgpin_en, cfg_rstpin_en, sys_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    syscfg_lockbank u0 (.*);

    // fields: cpu_we, cpu_addr, cpu_data, dbg_we, dbg_addr, dbg_data, exp_opt, exp_req
    localparam int NV = 7;
    localparam logic [42:0] VEC [0:NV-1] = '{
        {1'b1, 8'h00, 8'h3C, 1'b0, 8'h00, 8'h00, 8'h30, 1'b0}, // R3 first write, R2 bits 3:2 dropped
        {1'b1, 8'h00, 8'hFF, 1'b0, 8'h00, 8'h00, 8'h30, 1'b0}, // R4 second write ignored
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h01, 8'h01, 8'h30, 1'b1}, // R8 debug set
        {1'b1, 8'h01, 8'h01, 1'b0, 8'h00, 8'h00, 8'h30, 1'b0}, // R7 CPU to force-reset
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h01, 8'h00, 8'h30, 1'b0}, // R8 debug bit0 = 0
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 8'h01, 8'h30, 1'b0}, // R8 debug other address
        {1'b1, 8'h00, 8'h00, 1'b1, 8'h01, 8'hFF, 8'h30, 1'b1}  // R9 both, bank locked
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic cwe, input logic [7:0] ca, input logic [7:0] cd,
                        input logic dwe, input logic [7:0] da, input logic [7:0] dd,
                        input logic r);
        @(negedge clk);
        rst = r; bus_we = cwe; bus_addr = ca; bus_wdata = cd;
        dbg_we = dwe; dbg_addr = da; dbg_wdata = dd;
        @(negedge clk);
        rst = 1'b0; bus_we = 1'b0; dbg_we = 1'b0; bus_addr = A_OPT;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; bus_addr = A_OPT;
        #1;
    endtask

    initial begin
        do_reset();
        check("R1 reset value", bus_rdata, 8'hD2);
        check("R1 reset outputs", {3'b0, cfg_wdog_en, cfg_wdog_long, cfg_stop_en, cfg_dbgpin_en, cfg_rstpin_en}, 8'h1A);
        check("R1 no request", {7'b0, sys_rst_req}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][42], VEC[i][41:34], VEC[i][33:26], VEC[i][25], VEC[i][24:17], VEC[i][16:9], 1'b0);
            check($sformatf("R8 vector %0d request", i), {7'b0, sys_rst_req}, {7'b0, VEC[i][0]});
            check($sformatf("R4 vector %0d options", i), bus_rdata, VEC[i][8:1]);
        end

        bus_addr = A_FRC; #1;
        check("R6 force-reset reads zero", bus_rdata, 8'h00);

        // R5: reset and write in one cycle
        step(1'b1, A_OPT, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
        check("R5 write during reset dropped", bus_rdata, 8'hD2);
        step(1'b1, A_OPT, 8'h01, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R5 next write accepted", bus_rdata, 8'h01);

        // R10: unmapped address
        do_reset();
        step(1'b1, A_NONE, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R10 options unchanged", bus_rdata, 8'hD2);
        bus_addr = A_NONE; #1;
        check("R10 unmapped reads zero", bus_rdata, 8'h00);

        // R9: simultaneous writes on an unlocked bank
        step(1'b1, A_OPT, 8'h81, 1'b1, A_FRC, 8'h01, 1'b0);
        check("R9 options taken", bus_rdata, 8'h81);
        check("R9 request raised", {7'b0, sys_rst_req}, 8'h01);
        @(negedge clk); #1;
        check("R8 pulse one cycle", {7'b0, sys_rst_req}, 8'h00);

        // R11: output mapping for 0x81
        check("R11 wdog_en", {7'b0, cfg_wdog_en}, 8'h01);
        check("R11 wdog_long", {7'b0, cfg_wdog_long}, 8'h00);
        check("R11 stop_en", {7'b0, cfg_stop_en}, 8'h00);
        check("R11 dbgpin_en", {7'b0, cfg_dbgpin_en}, 8'h00);
        check("R11 rstpin_en", {7'b0, cfg_rstpin_en}, 8'h01);

        // R4: same value as defaults after lock is still ignored
        step(1'b1, A_OPT, 8'hD2, 1'b0, 8'h00, 8'h00, 1'b0);
        check("R4 default-valued write ignored", bus_rdata, 8'h81);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule